// File: doc/BRIEF.md
# Auxiliary packet mailbox

This block lets a processor exchange variable-length auxiliary packets with a peer over a simple word-wide link stream. It presents a Wishbone slave with two regions. The first is a packet window. Its lower half is the outgoing buffer, which software fills. Its upper half is the incoming buffer, which the block fills from the link. The second region is a small set of control and status registers. Software uses them to launch a send, wait until the send is finished, learn that a packet has arrived and how long it is, hand the incoming buffer back, and notice and clear overflow.

On the outgoing side, software waits until the busy register reads zero. It then writes the packet words into the lower half, writes the byte length and writes 1 to the start register. The block streams the words in address order, marks the final word, and drops busy once that word is accepted. On the incoming side, words are stored in order from the start of the upper half. When the word marked last arrives, the block latches the length and raises the present flag. A packet that starts while the flag is still set is discarded completely and sets a sticky error flag. Line coding, CRC and packet parsing are the job of neighbouring blocks.

Top module: `auxpkt_mailbox`

## Requirements
- R1: After reset, the busy, present and error registers read 0. The incoming-length and outgoing-length registers read 0. tx_valid is low.
- R2: Every Wishbone request (cyc and stb high) is acknowledged with a one-cycle wb_ack pulse in the cycle after the request. A word written to the lower half reads back unchanged at the same word address. The word address has 10 bits by default. Bit 9 set selects the registers, and the register offset is in bits 2:0. With bit 9 clear, bit 8 set selects the upper half and bit 8 clear selects the lower half. Bits 7:0 give the word within the half.
- R3: Writing 1 (bit 0) to the start register (offset 1) while idle sends ceil(L/4) words, where L is the value in the outgoing-length register (offset 0, 16 bits). The words come from lower-half word addresses 0 upward, and tx_last is high on the final word only. The busy register (offset 2) reads 1 from the start write until the final word is accepted, and reads 0 after that.
- R4: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values into the next cycle.
- R5: A start write while the outgoing length is 0 sends no word, and busy keeps reading 0.
- R6: An outgoing length larger than the half size (1024 bytes) sends exactly the 256 words of the lower half.
- R7: A start write made while busy is ignored. The packet in flight is not altered and no second packet follows.
- R8: Incoming words (rx_valid high) are written to upper-half word addresses 0 upward. The word with rx_last high raises the present flag (offset 3, bit 0). The incoming-length register (offset 4) then reads the word count times 4.
- R9: Writing 1 to bit 0 of the present register clears the flag and frees the incoming buffer. Writing 0 has no effect.
- R10: A packet whose first word arrives while present is set is dropped. The upper half and the incoming length stay unchanged, and the error flag (offset 5, bit 0) is set. The error flag stays set until 1 is written to it. Writing 0 leaves it set.
- R11: An incoming packet longer than 256 words keeps only its first 256 words, and its length reads 1024.
- R12: Wishbone writes to the upper half are ignored. A read of that word still returns what the link wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | 10 | Wishbone word address |
| wb_dat_w | input | 32 | Wishbone write data |
| wb_dat_r | output | 32 | Wishbone read data |
| wb_ack | output | 1 | Wishbone acknowledge |
| tx_valid | output | 1 | Outgoing word valid |
| tx_ready | input | 1 | Peer accepts outgoing word |
| tx_data | output | 32 | Outgoing word |
| tx_last | output | 1 | Outgoing word ends the packet |
| rx_valid | input | 1 | Incoming word valid |
| rx_data | input | 32 | Incoming word |
| rx_last | input | 1 | Incoming word ends the packet |

## Verification
The send path is exercised in loopback with three input patterns. With tx_ready held high, the test shows word order and last-word marking. With pseudo-random stalls, it shows that words are held rather than lost or duplicated. With tx_ready held low during a second start write, it shows that a restart mid-packet is ignored. Lengths of zero, non-multiples of four and far above the half size separate the rounding and clamping rules. A second packet arriving before release tells drop-and-flag apart from overwrite. An over-long packet driven directly on the link input checks that incoming storage saturates.

// File: rtl/auxpkt_pkg.sv
package auxpkt_pkg;
   typedef enum logic [2:0] {
      REG_TX_LEN  = 3'd0,
      REG_TX_GO   = 3'd1,
      REG_TX_BUSY = 3'd2,
      REG_RX_HAVE = 3'd3,
      REG_RX_LEN  = 3'd4,
      REG_RX_ERR  = 3'd5
   } reg_sel_e;

   typedef enum logic [1:0] {
      RD_TXMEM = 2'd0,
      RD_RXMEM = 2'd1,
      RD_CSR   = 2'd2
   } rd_src_e;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_FETCH = 2'd1,
      TX_SHOW  = 2'd2
   } tx_state_e;
endpackage

// File: rtl/auxpkt_ram.sv
module auxpkt_ram #(
   parameter int DW    = 32,
   parameter int DEPTH = 256,
   parameter int NRD   = 1,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [NRD*AW-1:0] raddr,
   output logic [NRD*DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_ff @(posedge clk) begin
         rdata[p*DW +: DW] <= mem[raddr[p*AW +: AW]];
      end
   end
endmodule

// File: rtl/auxpkt_tx.sv
module auxpkt_tx
   import auxpkt_pkg::*;
#(
   parameter int DW         = 32,
   parameter int LEN_W      = 16,
   parameter int HALF_WORDS = 256,
   localparam int AW        = $clog2(HALF_WORDS),
   localparam int BPW       = DW / 8,
   localparam int SH        = $clog2(BPW)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   output logic [AW-1:0]    rd_addr,
   input  logic [DW-1:0]    rd_q,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [DW-1:0]    tx_data,
   output logic             tx_last,
   output logic             busy
);
   tx_state_e     state;
   logic [AW-1:0] idx;
   logic [AW-1:0] last_idx;
   logic [LEN_W:0] wneed;
   logic [AW:0]    wtake;

   always_comb begin
      wneed = ({1'b0, len} + (LEN_W+1)'(BPW - 1)) >> SH;
      if (wneed > (LEN_W+1)'(HALF_WORDS)) wtake = (AW+1)'(HALF_WORDS);
      else                                 wtake = wneed[AW:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= TX_IDLE;
         idx      <= '0;
         last_idx <= '0;
      end else begin
         case (state)
            TX_IDLE: if (start && wtake != '0) begin
               idx      <= '0;
               last_idx <= AW'(wtake - 1'b1);
               state    <= TX_FETCH;
            end
            TX_FETCH: state <= TX_SHOW;
            TX_SHOW: if (tx_ready) begin
               if (idx == last_idx) state <= TX_IDLE;
               else begin
                  idx   <= idx + 1'b1;
                  state <= TX_FETCH;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign rd_addr  = idx;
   assign tx_valid = (state == TX_SHOW);
   assign tx_data  = rd_q;
   assign tx_last  = (idx == last_idx);
   assign busy     = (state != TX_IDLE);

   // R4: an offered word is held until accepted
   assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R3: busy only drops after the final word is taken
   assert_busy_end_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> $past(tx_valid && tx_ready && tx_last));

   // R7: a start pulse during a send does not restart it
   assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
      (busy && start && !(tx_valid && tx_ready)) |=> $stable(idx));
endmodule

// File: rtl/auxpkt_rx.sv
module auxpkt_rx #(
   parameter int DW         = 32,
   parameter int LEN_W      = 16,
   parameter int HALF_WORDS = 256,
   localparam int AW        = $clog2(HALF_WORDS),
   localparam int BPW       = DW / 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [DW-1:0]    in_data,
   input  logic             in_last,
   input  logic             release_i,
   input  logic             clear_err,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [DW-1:0]    wr_data,
   output logic             present,
   output logic [LEN_W-1:0] len,
   output logic             err
);
   logic [AW:0] cnt;
   logic [AW:0] cnt_next;
   logic        in_pkt;
   logic        dropping;
   logic        accept_now;
   logic        room;

   assign accept_now = in_pkt ? !dropping : !present;
   assign room       = (cnt < (AW+1)'(HALF_WORDS));
   assign cnt_next   = room ? cnt + 1'b1 : cnt;
   assign wr_en      = in_valid && accept_now && room;
   assign wr_addr    = cnt[AW-1:0];
   assign wr_data    = in_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt      <= '0;
         in_pkt   <= 1'b0;
         dropping <= 1'b0;
         present  <= 1'b0;
         len      <= '0;
         err      <= 1'b0;
      end else begin
         if (release_i) present <= 1'b0;
         if (clear_err) err <= 1'b0;
         if (in_valid) begin
            in_pkt <= !in_last;
            if (!in_pkt && present) begin
               dropping <= !in_last;
               err      <= 1'b1;
            end else if (in_last) begin
               dropping <= 1'b0;
            end
            if (accept_now) begin
               if (in_last) begin
                  cnt     <= '0;
                  len     <= LEN_W'(cnt_next * BPW);
                  present <= 1'b1;
               end else begin
                  cnt <= cnt_next;
               end
            end
         end
      end
   end

   // R10: a waiting packet's length cannot change until it is released
   assert_len_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (present && !release_i) |=> $stable(len));

   // R10: error flag is sticky until cleared
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      (err && !clear_err) |=> err);

   // R8: present rises only on an end-of-packet word
   assert_present_cause_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(present) |-> $past(in_valid && in_last));
endmodule

// File: rtl/auxpkt_mailbox.sv
module auxpkt_mailbox
   import auxpkt_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int WINDOW_BYTES = 2048,
   parameter int LEN_W        = 16,
   localparam int BPW         = DATA_W / 8,
   localparam int WORDS       = WINDOW_BYTES / BPW,
   localparam int HALF_WORDS  = WORDS / 2,
   localparam int HW_AW       = $clog2(HALF_WORDS),
   localparam int ADR_W       = HW_AW + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wb_cyc,
   input  logic              wb_stb,
   input  logic              wb_we,
   input  logic [ADR_W-1:0]  wb_adr,
   input  logic [DATA_W-1:0] wb_dat_w,
   output logic [DATA_W-1:0] wb_dat_r,
   output logic              wb_ack,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_last
);
   if (DATA_W % 8 != 0 || (BPW & (BPW - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if ((1 << HW_AW) != HALF_WORDS || HW_AW < 3) begin : g_bad_window
      $error("WINDOW_BYTES must give a power-of-two half of at least 8 words");
   end
   if (LEN_W < HW_AW + 1 || LEN_W > DATA_W || (HALF_WORDS * BPW) >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W must hold the half size in bytes and fit a data word");
   end

   logic            req;
   logic            is_csr;
   logic            is_rx;
   logic [HW_AW-1:0] offs;
   reg_sel_e        rsel;
   logic            wr;

   assign req    = wb_cyc && wb_stb && !wb_ack;
   assign is_csr = wb_adr[ADR_W-1];
   assign is_rx  = wb_adr[ADR_W-2];
   assign offs   = wb_adr[HW_AW-1:0];
   assign rsel   = reg_sel_e'(wb_adr[2:0]);
   assign wr     = req && wb_we;

   logic [LEN_W-1:0] tx_len_q;
   logic tx_go, rx_rel, rx_clr;
   assign tx_go  = wr && is_csr && rsel == REG_TX_GO   && wb_dat_w[0];
   assign rx_rel = wr && is_csr && rsel == REG_RX_HAVE && wb_dat_w[0];
   assign rx_clr = wr && is_csr && rsel == REG_RX_ERR  && wb_dat_w[0];

   always_ff @(posedge clk) begin
      if (rst) tx_len_q <= '0;
      else if (wr && is_csr && rsel == REG_TX_LEN) tx_len_q <= wb_dat_w[LEN_W-1:0];
   end

   // outgoing half: port 0 for the bus, port 1 for the sender
   logic [HW_AW-1:0]    tx_rd_addr;
   logic [2*DATA_W-1:0] txm_q;
   logic [DATA_W-1:0]   rxm_q;

   auxpkt_ram #(.DW(DATA_W), .DEPTH(HALF_WORDS), .NRD(2)) u_txmem (
      .clk(clk), .we(wr && !is_csr && !is_rx), .waddr(offs), .wdata(wb_dat_w),
      .raddr({tx_rd_addr, offs}), .rdata(txm_q));

   logic             rx_we;
   logic [HW_AW-1:0] rx_waddr;
   logic [DATA_W-1:0] rx_wdata;
   logic             rx_present, rx_err, tx_busy;
   logic [LEN_W-1:0] rx_len;

   auxpkt_ram #(.DW(DATA_W), .DEPTH(HALF_WORDS), .NRD(1)) u_rxmem (
      .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
      .raddr(offs), .rdata(rxm_q));

   auxpkt_tx #(.DW(DATA_W), .LEN_W(LEN_W), .HALF_WORDS(HALF_WORDS)) u_tx (
      .clk(clk), .rst(rst), .start(tx_go), .len(tx_len_q),
      .rd_addr(tx_rd_addr), .rd_q(txm_q[DATA_W +: DATA_W]),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .busy(tx_busy));

   auxpkt_rx #(.DW(DATA_W), .LEN_W(LEN_W), .HALF_WORDS(HALF_WORDS)) u_rx (
      .clk(clk), .rst(rst), .in_valid(rx_valid), .in_data(rx_data),
      .in_last(rx_last), .release_i(rx_rel), .clear_err(rx_clr),
      .wr_en(rx_we), .wr_addr(rx_waddr), .wr_data(rx_wdata),
      .present(rx_present), .len(rx_len), .err(rx_err));

   // read path: registered alongside the memory read
   logic [DATA_W-1:0] csr_val, csr_q;
   rd_src_e           src_q;

   always_comb begin
      csr_val = '0;
      case (rsel)
         REG_TX_LEN:  csr_val = DATA_W'(tx_len_q);
         REG_TX_BUSY: csr_val = DATA_W'(tx_busy);
         REG_RX_HAVE: csr_val = DATA_W'(rx_present);
         REG_RX_LEN:  csr_val = DATA_W'(rx_len);
         REG_RX_ERR:  csr_val = DATA_W'(rx_err);
         default:     csr_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wb_ack <= 1'b0;
         csr_q  <= '0;
         src_q  <= RD_CSR;
      end else begin
         wb_ack <= req;
         if (req) begin
            csr_q <= csr_val;
            src_q <= is_csr ? RD_CSR : (is_rx ? RD_RXMEM : RD_TXMEM);
         end
      end
   end

   always_comb begin
      case (src_q)
         RD_TXMEM: wb_dat_r = txm_q[DATA_W-1:0];
         RD_RXMEM: wb_dat_r = rxm_q;
         default:  wb_dat_r = csr_q;
      endcase
   end

   // R2: acknowledge is a single-cycle pulse
   assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      wb_ack |=> !wb_ack);

   // R2: no acknowledge without a request
   assert_ack_cause_R2: assert property (@(posedge clk) disable iff (rst)
      !(wb_cyc && wb_stb) |=> !wb_ack);

   // R1: nothing is offered on the link while the sender is idle
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !tx_busy |-> !tx_valid);
endmodule

// File: tb/sim_auxpkt_mailbox.sv
`timescale 1ns/1ps
module sim_auxpkt_mailbox;
   localparam logic [9:0] CSR = 10'h200;
   localparam logic [9:0] RXB = 10'h100;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
   logic [9:0] wb_adr = '0;
   logic [31:0] wb_dat_w = '0, wb_dat_r;
   logic wb_ack;
   logic tx_valid, tx_last, tx_ready = 1'b1;
   logic [31:0] tx_data;
   logic loop_en = 1'b1;
   logic d_valid = 0, d_last = 0;
   logic [31:0] d_data = '0;
   logic rx_valid, rx_last;
   logic [31:0] rx_data;

   assign rx_valid = loop_en ? (tx_valid && tx_ready) : d_valid;
   assign rx_data  = loop_en ? tx_data : d_data;
   assign rx_last  = loop_en ? tx_last : d_last;

   auxpkt_mailbox u0 (.*);

   int n_chk = 0, n_fail = 0;
   logic [32:0] exp_q[$];
   int rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int seed, input int i);
      return {seed[15:0], i[15:0]} ^ 32'h3C00_0000;
   endfunction

   always begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
         0: tx_ready = 1'b1;
         1: tx_ready = lfsr[0] & lfsr[3];
         default: tx_ready = 1'b0;
      endcase
   end

   // monitor: scoreboard on accepted words, and hold check while stalled
   logic stall_prev = 0;
   logic [31:0] stall_data;
   always @(negedge clk) begin
      if (!rst) begin
         if (stall_prev) begin
            chk("R4 hold valid", {31'd0, tx_valid}, 32'd1);
            chk("R4 hold data", tx_data, stall_data);
         end
         stall_prev = tx_valid && !tx_ready;
         stall_data = tx_data;
         if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
               chk("R3 unexpected word", tx_data, 32'hxxxx_xxxx);
               n_fail += (tx_data === 32'hxxxx_xxxx) ? 1 : 0;
            end else begin
               logic [32:0] e;
               e = exp_q.pop_front();
               chk("R3 word data", tx_data, e[31:0]);
               chk("R3 last flag", {31'd0, tx_last}, {31'd0, e[32]});
            end
         end
      end
   end

   task automatic wb_wr(input logic [9:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = a; wb_dat_w = d;
      do @(negedge clk); while (!wb_ack);
      @(posedge clk); #1;
      wb_cyc = 0; wb_stb = 0; wb_we = 0;
   endtask

   task automatic wb_rd(input logic [9:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = a;
      do @(negedge clk); while (!wb_ack);
      d = wb_dat_r;
      @(posedge clk); #1;
      wb_cyc = 0; wb_stb = 0;
   endtask

   task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
      logic [31:0] d;
      wb_rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic fill(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         wb_wr(10'(i), pat(seed, i));
         exp_q.push_back({(i == n - 1), pat(seed, i)});
      end
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] d;
      for (int k = 0; k < 3000; k++) begin
         wb_rd(CSR + 10'd2, d);
         if (d == 0) break;
      end
      chk(tag, d, 32'd0);
      repeat (4) @(posedge clk);
      chk({tag, " queue drained"}, 32'(exp_q.size()), 32'd0);
   endtask

   task automatic send(input int len, input int seed, input string tag);
      int n;
      n = (len + 3) / 4;
      if (n > 256) n = 256;
      fill(n, seed);
      wb_wr(CSR + 10'd0, 32'(len));
      wb_wr(CSR + 10'd1, 32'd1);
      wait_idle(tag);
   endtask

   task automatic rx_verify(input int n, input int seed, input string tag);
      for (int i = 0; i < n; i++) rd_chk(tag, RXB + 10'(i), pat(seed, i));
   endtask

   task automatic summary;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] d;
      repeat (4) @(posedge clk);
      #1 rst = 0;
      @(negedge clk);
      chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
      rd_chk("R1 busy", CSR + 10'd2, 32'd0);
      rd_chk("R1 present", CSR + 10'd3, 32'd0);
      rd_chk("R1 error", CSR + 10'd5, 32'd0);
      rd_chk("R1 rx len", CSR + 10'd4, 32'd0);
      rd_chk("R1 tx len", CSR + 10'd0, 32'd0);

      // R2: read-back of outgoing half
      wb_wr(10'd5, 32'hDEAD_BEEF);
      rd_chk("R2 readback", 10'd5, 32'hDEAD_BEEF);
      @(negedge clk);
      chk("R2 ack ends", {31'd0, wb_ack}, 32'd0);

      // R3 / R8: loopback, no stalls, non-multiple length
      send(10, 1, "R3 busy clears");
      rd_chk("R8 present", CSR + 10'd3, 32'd1);
      rd_chk("R8 rx len", CSR + 10'd4, 32'd12);
      rx_verify(3, 1, "R8 rx data");

      // R9: release semantics
      wb_wr(CSR + 10'd3, 32'd0);
      rd_chk("R9 write0 keeps", CSR + 10'd3, 32'd1);
      wb_wr(CSR + 10'd3, 32'd1);
      rd_chk("R9 release", CSR + 10'd3, 32'd0);

      // R4: stalled link
      rdy_mode = 1;
      send(17, 2, "R4 busy clears");
      rdy_mode = 0;
      rd_chk("R8 rx len stalled", CSR + 10'd4, 32'd20);
      rx_verify(5, 2, "R8 rx data stalled");

      // R10: second packet while present is set
      send(8, 3, "R10 send");
      rd_chk("R10 error set", CSR + 10'd5, 32'd1);
      rd_chk("R10 len kept", CSR + 10'd4, 32'd20);
      rd_chk("R10 data kept", RXB, pat(2, 0));
      wb_wr(CSR + 10'd5, 32'd0);
      rd_chk("R10 sticky", CSR + 10'd5, 32'd1);
      wb_wr(CSR + 10'd3, 32'd1);
      wb_wr(CSR + 10'd5, 32'd1);
      rd_chk("R10 cleared", CSR + 10'd5, 32'd0);
      send(8, 4, "R10 resend");
      rd_chk("R10 accepted", CSR + 10'd3, 32'd1);
      rx_verify(2, 4, "R10 new data");
      wb_wr(CSR + 10'd3, 32'd1);

      // R5: zero length
      wb_wr(CSR + 10'd0, 32'd0);
      wb_wr(CSR + 10'd1, 32'd1);
      rd_chk("R5 busy stays 0", CSR + 10'd2, 32'd0);
      repeat (20) @(posedge clk);
      rd_chk("R5 nothing received", CSR + 10'd3, 32'd0);

      // R7: start while busy
      rdy_mode = 2;
      fill(4, 5);
      wb_wr(CSR + 10'd0, 32'd16);
      wb_wr(CSR + 10'd1, 32'd1);
      rd_chk("R3 busy during send", CSR + 10'd2, 32'd1);
      wb_wr(CSR + 10'd0, 32'd40);
      wb_wr(CSR + 10'd1, 32'd1);
      rdy_mode = 0;
      wait_idle("R7 single packet");
      repeat (20) @(posedge clk);
      chk("R7 no extra words", 32'(exp_q.size()), 32'd0);
      rd_chk("R7 rx len", CSR + 10'd4, 32'd16);
      wb_wr(CSR + 10'd3, 32'd1);

      // R6: oversized length clamps to the half
      send(2000, 6, "R6 busy clears");
      rd_chk("R6 rx len", CSR + 10'd4, 32'd1024);
      rd_chk("R6 last word", RXB + 10'd255, pat(6, 255));
      wb_wr(CSR + 10'd3, 32'd1);

      // R11: over-long incoming packet, driven directly
      loop_en = 0;
      for (int i = 0; i < 260; i++) begin
         @(posedge clk); #1;
         d_valid = 1; d_data = pat(7, i); d_last = (i == 259);
      end
      @(posedge clk); #1;
      d_valid = 0; d_last = 0;
      rd_chk("R11 present", CSR + 10'd3, 32'd1);
      rd_chk("R11 len saturates", CSR + 10'd4, 32'd1024);
      rd_chk("R11 first word", RXB, pat(7, 0));
      rd_chk("R11 word 255", RXB + 10'd255, pat(7, 255));

      // R12: bus writes to the incoming half are ignored
      wb_wr(RXB + 10'd1, 32'h1234_5678);
      rd_chk("R12 rx half unchanged", RXB + 10'd1, pat(7, 1));

      repeat (5) @(posedge clk);
      summary();
   end
endmodule